// File: doc/BRIEF.md
# Register-Driven Multiply-Accumulate Unit

A processor-attached arithmetic unit reached through a small word-addressed register port. The narrow path takes two 16-bit operands and one of four operations: unsigned multiply, signed multiply, unsigned multiply-accumulate or signed multiply-accumulate. The wide path takes two 32-bit operands and forms a 64-bit product, either unsigned or signed.

Software first writes the first operand. For the narrow path, the operation code travels in the upper bits of that same write. For the wide path, the address written selects signed or unsigned. Writing the second operand runs the operation in the same clock edge, and the results can be read from the next cycle onward.

Operand registers hold exactly their architectural width. Unsigned products are therefore formed from zero-extended operands. Signed products are formed from operands sign-extended from their top bit.

Each narrow operation updates two result registers and two accumulator registers, one unsigned view and one signed view of each. Both views carry the same 32-bit pattern, because 32-bit two's-complement addition is the same operation on signed and unsigned numbers.

Top module: `mac_periph`

## Requirements
- R1: After reset, every register reads zero. The narrow operation code reads back as 0, which means unsigned multiply.
- R2: Operation code 0 (unsigned multiply) zero-extends both 16-bit operands. Both result registers (word 2 unsigned view, word 3 signed view) receive the full 32-bit product. For example, 0xFFFF times 0xFFFF gives 0xFFFE0001.
- R3: Operation code 1 (signed multiply) sign-extends both operands from bit 15. Both result registers receive the signed product pattern. For example, 0xFFFF times 0x0002 gives 0xFFFFFFFE.
- R4: Operation codes 0 and 1 clear both accumulators (word 4 unsigned view, word 5 signed view) to zero.
- R5: Operation code 2 (unsigned multiply-accumulate) adds the zero-extended product to both accumulators, wrapping modulo 2^32 with no saturation. Both result registers are then loaded with the updated accumulator value.
- R6: Operation code 3 (signed multiply-accumulate) sign-extends both operands from bit 15 and adds the 32-bit product pattern to both accumulators. Both result registers are then loaded with the updated accumulator value.
- R7: The wide unsigned mode zero-extends both 32-bit operands to 64 bits. The first operand is written at word 6 and the second at word 8. The product is read at word 9 (low half) and word 10 (high half). For example, 0xFFFFFFFC times 0x2 gives 0x1_FFFFFFF8.
- R8: The wide signed mode sign-extends both operands from bit 31. It is selected by writing the first operand at word 7. For example, 0xFFFFFFFC times 0x2 gives 0xFFFFFFFF_FFFFFFF8.
- R9: Word 0 latches the narrow first operand from write data bits 15:0 and the operation code from bits 17:16. Writing word 1 triggers the narrow operation. Results change only when a second operand is written. Writes to result, accumulator and product words are ignored.
- R10: Read data is registered: the value of the word addressed in one cycle appears on the read port after the next clock edge. Word 0 reads back the operation code in bits 17:16 and the operand in bits 15:0. Words 6 and 7 both read the wide first operand. Words 11 to 15 read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Word address for both read and write |
| reg_we | input | 1 | Write strobe for the addressed word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data of the word addressed in the previous cycle |

## Verification
The assertions assume that the write strobe and address are known on every clock edge after reset. They also assume that a trigger write uses the operation code latched by an earlier first-operand write. The bench drives every input on the falling edge, with strobe and address always defined, and always writes the first operand before the second. The bench relies on the equal-pattern property of the two views: its model updates both from one product, so any divergence shows up in the read data it compares on every clock.

// File: rtl/mac_pkg.sv
`timescale 1ns/1ps
package mac_pkg;
    localparam int OP_W    = 16;
    localparam int WIDE_W  = 32;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 4;
    localparam int MODE_LO = OP_W;

    typedef enum logic [1:0] {
        OP_UMUL = 2'd0,
        OP_SMUL = 2'd1,
        OP_UMAC = 2'd2,
        OP_SMAC = 2'd3
    } op_e;

    localparam int W_OPA   = 0;
    localparam int W_OPB   = 1;
    localparam int W_RESU  = 2;
    localparam int W_RESS  = 3;
    localparam int W_ACCU  = 4;
    localparam int W_ACCS  = 5;
    localparam int W_WAU   = 6;
    localparam int W_WAS   = 7;
    localparam int W_WB    = 8;
    localparam int W_PLO   = 9;
    localparam int W_PHI   = 10;
endpackage

// File: rtl/mac_mult.sv
`timescale 1ns/1ps
module mac_mult #(
    parameter int W = 16
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           sgn,
    output logic [2*W-1:0] p
);
    localparam int PW = 2 * W;

    logic [PW-1:0] ea;
    logic [PW-1:0] eb;

    always_comb begin
        ea = {{W{sgn & a[W-1]}}, a};
        eb = {{W{sgn & b[W-1]}}, b};
        p  = PW'(ea * eb);
    end
endmodule

// File: rtl/mac_rdmux.sv
`timescale 1ns/1ps
module mac_rdmux
    import mac_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 32,
    parameter int NW = 16,
    parameter int WW = 32
) (
    input  logic [AW-1:0]   addr,
    input  logic [NW-1:0]   op_a,
    input  logic [1:0]      op,
    input  logic [NW-1:0]   op_b,
    input  logic [2*NW-1:0] res_u,
    input  logic [2*NW-1:0] res_s,
    input  logic [2*NW-1:0] acc_u,
    input  logic [2*NW-1:0] acc_s,
    input  logic [WW-1:0]   wa,
    input  logic [WW-1:0]   wb,
    input  logic [2*WW-1:0] prod,
    output logic [DW-1:0]   rd
);
    always_comb begin
        rd = '0;
        case (addr)
            AW'(W_OPA):  rd = DW'({op, op_a});
            AW'(W_OPB):  rd = DW'(op_b);
            AW'(W_RESU): rd = DW'(res_u);
            AW'(W_RESS): rd = DW'(res_s);
            AW'(W_ACCU): rd = DW'(acc_u);
            AW'(W_ACCS): rd = DW'(acc_s);
            AW'(W_WAU):  rd = DW'(wa);
            AW'(W_WAS):  rd = DW'(wa);
            AW'(W_WB):   rd = DW'(wb);
            AW'(W_PLO):  rd = DW'(prod[WW-1:0]);
            AW'(W_PHI):  rd = DW'(prod[2*WW-1:WW]);
            default:     rd = '0;
        endcase
    end
endmodule

// File: rtl/mac_periph.sv
`timescale 1ns/1ps
module mac_periph
    import mac_pkg::*;
#(
    parameter int NW  = OP_W,
    parameter int WW  = WIDE_W,
    parameter int DW  = DATA_W,
    parameter int AW  = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_we,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata
);
    localparam int RW  = 2 * NW;
    localparam int PW  = 2 * WW;
    localparam int MLO = NW;

    typedef struct packed {
        logic [NW-1:0] op_a;
        logic [1:0]    op;
        logic [NW-1:0] op_b;
        logic [RW-1:0] res_u;
        logic [RW-1:0] res_s;
        logic [RW-1:0] acc_u;
        logic [RW-1:0] acc_s;
        logic [WW-1:0] wa;
        logic          wsgn;
        logic [WW-1:0] wb;
        logic [PW-1:0] prod;
        logic [DW-1:0] rdata;
    } state_t;

    state_t st_d, st_q;

    logic [RW-1:0] nprod;
    logic [PW-1:0] wprod;
    logic [DW-1:0] rd_val;
    logic          nsgn;

    // Narrow operand sign flag: odd operation codes are the signed ones
    assign nsgn = st_q.op[0];

    mac_mult #(.W(NW)) u_nmul (
        .a   (st_q.op_a),
        .b   (reg_wdata[NW-1:0]),
        .sgn (nsgn),
        .p   (nprod)
    );

    mac_mult #(.W(WW)) u_wmul (
        .a   (st_q.wa),
        .b   (reg_wdata[WW-1:0]),
        .sgn (st_q.wsgn),
        .p   (wprod)
    );

    mac_rdmux #(.AW(AW), .DW(DW), .NW(NW), .WW(WW)) u_rd (
        .addr  (reg_addr),
        .op_a  (st_q.op_a),
        .op    (st_q.op),
        .op_b  (st_q.op_b),
        .res_u (st_q.res_u),
        .res_s (st_q.res_s),
        .acc_u (st_q.acc_u),
        .acc_s (st_q.acc_s),
        .wa    (st_q.wa),
        .wb    (st_q.wb),
        .prod  (st_q.prod),
        .rd    (rd_val)
    );

    always_comb begin
        st_d       = st_q;
        st_d.rdata = rd_val;
        if (reg_we) begin
            case (reg_addr)
                AW'(W_OPA): begin
                    st_d.op_a = reg_wdata[NW-1:0];
                    st_d.op   = reg_wdata[MLO+1:MLO];
                end
                AW'(W_OPB): begin
                    st_d.op_b = reg_wdata[NW-1:0];
                    if (st_q.op[1]) begin
                        // accumulate: both views add the same 32-bit pattern
                        st_d.acc_u = st_q.acc_u + nprod;
                        st_d.acc_s = st_q.acc_s + nprod;
                        st_d.res_u = st_q.acc_u + nprod;
                        st_d.res_s = st_q.acc_s + nprod;
                    end else begin
                        st_d.res_u = nprod;
                        st_d.res_s = nprod;
                        st_d.acc_u = '0;
                        st_d.acc_s = '0;
                    end
                end
                AW'(W_WAU): begin
                    st_d.wa   = reg_wdata[WW-1:0];
                    st_d.wsgn = 1'b0;
                end
                AW'(W_WAS): begin
                    st_d.wa   = reg_wdata[WW-1:0];
                    st_d.wsgn = 1'b1;
                end
                AW'(W_WB): begin
                    st_d.wb   = reg_wdata[WW-1:0];
                    st_d.prod = wprod;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata = st_q.rdata;

    // Named views for the bound checker
    logic [1:0]    chk_op;
    logic          chk_wsgn;
    logic [RW-1:0] chk_res_u, chk_res_s, chk_acc_u, chk_acc_s;
    logic [WW-1:0] chk_prod_hi;
    assign chk_op      = st_q.op;
    assign chk_wsgn    = st_q.wsgn;
    assign chk_res_u   = st_q.res_u;
    assign chk_res_s   = st_q.res_s;
    assign chk_acc_u   = st_q.acc_u;
    assign chk_acc_s   = st_q.acc_s;
    assign chk_prod_hi = st_q.prod[PW-1:WW];
endmodule

// File: rtl/mac_periph_chk.sv
`timescale 1ns/1ps
module mac_periph_chk
    import mac_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int RW = 2 * OP_W,
    parameter int WW = WIDE_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          we,
    input logic [AW-1:0] addr,
    input logic [1:0]    op,
    input logic          wsgn,
    input logic [RW-1:0] res_u,
    input logic [RW-1:0] res_s,
    input logic [RW-1:0] acc_u,
    input logic [RW-1:0] acc_s,
    input logic [WW-1:0] prod_hi
);
    logic trig_n, trig_w;
    assign trig_n = we && (addr == AW'(W_OPB));
    assign trig_w = we && (addr == AW'(W_WB));

    AST_UMUL_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_n && op == 2'd0) |=> (res_u[RW-1:RW/2] != '1)); // R2

    AST_VIEWS_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_n |=> (res_u == res_s)); // R3

    AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_n && !op[1]) |=> (acc_u == '0 && acc_s == '0)); // R4

    AST_MAC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_n && op[1]) |=> (res_u == acc_u && res_s == acc_s)); // R5

    AST_WIDE_UNS: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_w && !wsgn) |=> (prod_hi != '1)); // R7

    AST_HOLD_RES: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_n |=> ($stable(res_u) && $stable(acc_u) && $stable(acc_s))); // R9

    AST_HOLD_PROD: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_w |=> $stable(prod_hi)); // R9
endmodule

bind mac_periph mac_periph_chk #(.AW(AW), .RW(2*NW), .WW(WW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (reg_we),
    .addr    (reg_addr),
    .op      (chk_op),
    .wsgn    (chk_wsgn),
    .res_u   (chk_res_u),
    .res_s   (chk_res_s),
    .acc_u   (chk_acc_u),
    .acc_s   (chk_acc_s),
    .prod_hi (chk_prod_hi)
);

// File: tb/sim_mac_periph.sv
`timescale 1ns/1ps
module sim_mac_periph;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    mac_periph u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_we(we),
        .reg_wdata(wdata), .reg_rdata(rdata)
    );

    // behavioural reference state
    logic [15:0] m_a, m_b;
    logic [1:0]  m_op;
    logic [31:0] m_ru, m_rs, m_au, m_as, m_wa, m_wb;
    logic        m_ws;
    logic [63:0] m_p;

    function automatic logic [31:0] m_read(input logic [3:0] a);
        case (a)
            4'd0:  return {14'd0, m_op, m_a};
            4'd1:  return {16'd0, m_b};
            4'd2:  return m_ru;
            4'd3:  return m_rs;
            4'd4:  return m_au;
            4'd5:  return m_as;
            4'd6, 4'd7: return m_wa;
            4'd8:  return m_wb;
            4'd9:  return m_p[31:0];
            4'd10: return m_p[63:32];
            default: return 32'd0;
        endcase
    endfunction

    task automatic m_write(input logic [3:0] a, input logic [31:0] d);
        int          sa, sb;
        int unsigned ua, ub, pr;
        longint          la, lb;
        longint unsigned wa, wb;
        case (a)
            4'd0: begin m_a = d[15:0]; m_op = d[17:16]; end
            4'd1: begin
                m_b = d[15:0];
                if (m_op[0]) begin
                    sa = int'($signed(m_a)); sb = int'($signed(m_b));
                    pr = int'(sa * sb);
                end else begin
                    ua = m_a; ub = m_b;
                    pr = ua * ub;
                end
                if (m_op[1]) begin
                    m_au = m_au + pr; m_as = m_as + pr;
                    m_ru = m_au; m_rs = m_as;
                end else begin
                    m_ru = pr; m_rs = pr; m_au = 0; m_as = 0;
                end
            end
            4'd6: begin m_wa = d; m_ws = 1'b0; end
            4'd7: begin m_wa = d; m_ws = 1'b1; end
            4'd8: begin
                m_wb = d;
                if (m_ws) begin
                    la = longint'($signed(m_wa)); lb = longint'($signed(d));
                    m_p = la * lb;
                end else begin
                    wa = m_wa; wb = d;
                    m_p = wa * wb;
                end
            end
            default: ;
        endcase
    endtask

    // one clock: drive, predict, compare read data of this cycle's address
    task automatic step(input logic [3:0] a, input logic w, input logic [31:0] d,
                        input string tag);
        logic [31:0] exp;
        @(negedge clk);
        addr = a; we = w; wdata = d;
        exp = m_read(a);
        if (w) m_write(a, d);
        @(posedge clk);
        #1;
        n_tests++;
        if (rdata !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, rdata, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, input string tag);
        step(a, 1'b0, 32'd0, tag);
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        m_a = 0; m_b = 0; m_op = 0; m_ru = 0; m_rs = 0; m_au = 0; m_as = 0;
        m_wa = 0; m_wb = 0; m_ws = 0; m_p = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state of every word
        for (int i = 0; i < 16; i++) rd(4'(i), "R1");

        // R2: unsigned 16x16 with all-ones operands
        step(4'd0, 1, 32'h0000_FFFF, "R9");
        step(4'd1, 1, 32'h0000_FFFF, "R9");
        rd(4'd2, "R2"); rd(4'd3, "R2"); rd(4'd3, "R2");
        if (m_ru != 32'hFFFE0001) begin n_fail++; $display("FAIL R2 actual=%h expected=fffe0001", m_ru); end

        // R3: signed 16x16, -1 * 2
        step(4'd0, 1, 32'h0001_FFFF, "R3");
        rd(4'd0, "R10");
        step(4'd1, 1, 32'h0000_0002, "R3");
        rd(4'd2, "R3"); rd(4'd3, "R3"); rd(4'd4, "R4");

        // R5: unsigned accumulate with wrap
        step(4'd0, 1, 32'h0002_FFFF, "R5");
        step(4'd1, 1, 32'h0000_FFFF, "R5");
        step(4'd1, 1, 32'h0000_FFFF, "R5");
        rd(4'd4, "R5"); rd(4'd5, "R5"); rd(4'd2, "R5"); rd(4'd3, "R5");

        // R6: signed accumulate adds -2
        step(4'd0, 1, 32'h0003_FFFF, "R6");
        step(4'd1, 1, 32'h0000_0002, "R6");
        rd(4'd4, "R6"); rd(4'd5, "R6"); rd(4'd2, "R6");
        step(4'd0, 1, 32'h0003_8000, "R6");
        step(4'd1, 1, 32'h0000_8000, "R6");
        rd(4'd4, "R6"); rd(4'd3, "R6");

        // R9: first-operand write alone and result-word writes change nothing
        step(4'd0, 1, 32'h0000_0003, "R9");
        rd(4'd4, "R9"); rd(4'd2, "R9");
        step(4'd2, 1, 32'h1234_5678, "R9");
        step(4'd4, 1, 32'h1234_5678, "R9");
        rd(4'd2, "R9"); rd(4'd4, "R9");

        // R4: non-accumulate clears both accumulators
        step(4'd1, 1, 32'h0000_0005, "R4");
        rd(4'd4, "R4"); rd(4'd5, "R4"); rd(4'd2, "R4");

        // R7: wide unsigned
        step(4'd6, 1, 32'hFFFF_FFFC, "R7");
        step(4'd8, 1, 32'h0000_0002, "R7");
        rd(4'd9, "R7"); rd(4'd10, "R7");
        if (m_p != 64'h1_FFFF_FFF8) begin n_fail++; $display("FAIL R7 actual=%h expected=1fffffff8", m_p); end

        // R8: wide signed
        step(4'd7, 1, 32'hFFFF_FFFC, "R8");
        rd(4'd7, "R10");
        step(4'd8, 1, 32'h0000_0002, "R8");
        rd(4'd9, "R8"); rd(4'd10, "R8");
        step(4'd7, 1, 32'h8000_0000, "R8");
        step(4'd8, 1, 32'h8000_0000, "R8");
        rd(4'd10, "R8"); rd(4'd9, "R8");
        step(4'd6, 1, 32'hFFFF_FFFF, "R7");
        step(4'd8, 1, 32'hFFFF_FFFF, "R7");
        rd(4'd10, "R7"); rd(4'd9, "R7");

        // R10: unmapped words read zero, latency of one cycle back to back
        rd(4'd11, "R10"); rd(4'd15, "R10"); rd(4'd8, "R10"); rd(4'd1, "R10");

        n_tests += 2;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule